// File: doc/BRIEF.md
# Serial Flash Write-Permission Controller

This block holds the write-permission state of a serial flash device. It watches the device's SPI pins: serial clock, serial data in and an active-low chip select. It decodes one-byte commands, plus one two-byte command that carries a data byte. It keeps three flags:

- a write-enable latch (WEL);
- an auto-address-increment (AAI) program mode bit;
- an arm flag that permits one status-register write.

A program/erase engine elsewhere reads these flags. It asks the block for permission before it starts an operation. It reports back when an operation completes.

The three SPI inputs pass through synchronisers into the system clock. Bits are shifted in, most significant bit first, on each rising serial clock edge while chip select is low. Nothing is decided until chip select rises again. At that moment the bit count and the opcode are judged together. A good frame commits, and a malformed frame is dropped without changing any flag.

The engine side uses plain single-cycle pulses. It has no valid/ready handshake, because no request can be held off: a request is either granted in the next cycle or refused outright. The serial output is never driven.

Top module: `spi_wperm_ctrl`

## Requirements
- R1: After reset, wel_o, aai_o, sr_write_ok_o, sr_accept_o and pe_grant_o are all 0.
- R2: An 8-bit frame carrying opcode 0x06 sets wel_o to 1. The command commits on the third rising clk edge after csn_i is driven high, and not before csn_i rises.
- R3: An 8-bit frame carrying opcode 0x04 clears both wel_o and aai_o to 0.
- R4: sdi_i is sampled on rising sck_i edges with the most significant bit first. Either sck_i idle level (low, or high) is accepted. A frame 0x60 is therefore not taken as 0x06.
- R5: An 8-bit frame with opcode 0x50 sets sr_write_ok_o. A following 16-bit frame (opcode byte 0x01, then a data byte) produces a one-cycle sr_accept_o pulse, with sr_data_o equal to the data byte. It also clears wel_o and sr_write_ok_o.
- R6: The arm is consumed by the next well-formed command. Any well-formed command other than 0x50 clears sr_write_ok_o, and a 0x01 frame with no arm produces no pulse and changes nothing.
- R7: A frame whose bit count is not 8 (or not 16 when the opcode byte is 0x01) changes no flag, and an existing arm survives it.
- R8: pe_req_i high while wel_o is 1 yields a one-cycle pe_grant_o on the next cycle; with wel_o at 0 no grant is given. pe_done_i clears wel_o.
- R9: aai_enter_i sets aai_o only while wel_o is 1. aai_o is cleared only by opcode 0x04 or reset, not by pe_done_i or by a status write.
- R10: When a command commits in the same cycle as pe_done_i, the command's effect on wel_o wins. When a 0x04 commits in the same cycle as aai_enter_i, aai_o ends 0.
- R11: sdo_oe_o is 0 at all times, so the serial output stays high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI serial clock |
| sdi_i | input | 1 | SPI serial data in |
| csn_i | input | 1 | SPI chip select, active low |
| sdo_o | output | 1 | SPI serial data out (value when driven) |
| sdo_oe_o | output | 1 | Output enable for sdo_o, always 0 |
| pe_req_i | input | 1 | Program/erase request pulse |
| pe_done_i | input | 1 | Program/erase completion pulse |
| aai_enter_i | input | 1 | Engine entering auto-address-increment mode |
| pe_grant_o | output | 1 | Request granted, one-cycle pulse |
| wel_o | output | 1 | Write-enable latch |
| aai_o | output | 1 | Auto-address-increment mode bit |
| sr_write_ok_o | output | 1 | Status-register write armed |
| sr_accept_o | output | 1 | Status write accepted, one-cycle pulse |
| sr_data_o | output | 8 | Data byte of the accepted status write |

## Verification
Two pairs of functions can land on one clock edge. In the first, a serial command commits while the engine reports completion. In the second, a write-disable commits while the engine asks to enter AAI mode. The bench provokes each collision by raising the engine pulse exactly on the commit edge. It locates that edge from the fixed synchroniser latency after chip select rises. It then judges the outcome by the flags: write-enable must stay set, and AAI must stay clear.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = 2 * BYTE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  typedef enum logic [BYTE_W-1:0] {
    CMD_SR_WRITE = 8'h01,
    CMD_WR_OFF   = 8'h04,
    CMD_WR_ON    = 8'h06,
    CMD_SR_ARM   = 8'h50
  } cmd_e;
endpackage

// File: rtl/spi_wp_sync.sv
module spi_wp_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= stage_q[STAGES-1];

  assign level_o = stage_q[STAGES-1];
  assign rise_o  = stage_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/spi_wp_frame.sv
module spi_wp_frame
  import spi_wp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_rise_i,
  input  logic               sdi_i,
  input  logic               csn_i,
  input  logic               cs_fall_i,
  input  logic               cs_rise_i,
  output logic               frame_end_o,
  output logic [CNT_W-1:0]   bit_cnt_o,
  output logic [FRAME_W-1:0] bits_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shift_q;
  logic               take_bit;

  assign take_bit = sck_rise_i && !csn_i && !cs_fall_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (cs_fall_i) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (take_bit) begin
      shift_q <= {shift_q[FRAME_W-2:0], sdi_i};
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign frame_end_o = cs_rise_i;
  assign bit_cnt_o   = cnt_q;
  assign bits_o      = shift_q;

  a_r7_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_i |=> cnt_q == '0);
  a_r4_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (take_bit && cnt_q != CNT_SAT) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_i && !cs_fall_i) |=> $stable(shift_q));
endmodule

// File: rtl/spi_wp_perm.sv
module spi_wp_perm
  import spi_wp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_end_i,
  input  logic [CNT_W-1:0]   bit_cnt_i,
  input  logic [FRAME_W-1:0] bits_i,
  input  logic               pe_req_i,
  input  logic               pe_done_i,
  input  logic               aai_enter_i,
  output logic               pe_grant_o,
  output logic               wel_o,
  output logic               aai_o,
  output logic               arm_o,
  output logic               sr_accept_o,
  output logic [BYTE_W-1:0]  sr_data_o
);
  logic              wel_q, aai_q, arm_q;
  logic              len_short, len_long, cmd_ok;
  logic [BYTE_W-1:0] op_short, op_long, data_long;

  assign op_short  = bits_i[BYTE_W-1:0];
  assign op_long   = bits_i[FRAME_W-1:BYTE_W];
  assign data_long = bits_i[BYTE_W-1:0];
  assign len_short = bit_cnt_i == CNT_W'(BYTE_W);
  assign len_long  = bit_cnt_i == CNT_W'(FRAME_W);
  assign cmd_ok    = frame_end_i &&
                     ((len_short && op_short != CMD_SR_WRITE) ||
                      (len_long  && op_long  == CMD_SR_WRITE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q       <= 1'b0;
      aai_q       <= 1'b0;
      arm_q       <= 1'b0;
      sr_accept_o <= 1'b0;
      sr_data_o   <= '0;
      pe_grant_o  <= 1'b0;
    end else begin
      sr_accept_o <= 1'b0;
      pe_grant_o  <= pe_req_i && wel_q;
      if (pe_done_i) wel_q <= 1'b0;
      if (aai_enter_i && wel_q) aai_q <= 1'b1;
      if (cmd_ok) begin
        arm_q <= len_short && op_short == CMD_SR_ARM;
        if (len_short && op_short == CMD_WR_ON) wel_q <= 1'b1;
        if (len_short && op_short == CMD_WR_OFF) begin
          wel_q <= 1'b0;
          aai_q <= 1'b0;
        end
        if (len_long && arm_q) begin
          sr_accept_o <= 1'b1;
          sr_data_o   <= data_long;
          wel_q       <= 1'b0;
        end
      end
    end
  end

  assign wel_o = wel_q;
  assign aai_o = aai_q;
  assign arm_o = arm_q;

  a_r2_wel_set: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && len_short && op_short == CMD_WR_ON) |=> wel_q);
  a_r2_wel_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(frame_end_i && len_short && op_short == CMD_WR_ON));
  a_r3_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && len_short && op_short == CMD_WR_OFF) |=> (!wel_q && !aai_q));
  a_r5_accept_armed: assert property (@(posedge clk) disable iff (!rst_n)
    sr_accept_o |-> ($past(arm_q) && !arm_q && !wel_q));
  a_r8_grant_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    pe_grant_o |-> $past(wel_q && pe_req_i));
  a_r9_aai_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aai_q) |-> $past(wel_q && aai_enter_i));
  a_r9_aai_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aai_q) |-> $past(frame_end_i && len_short && op_short == CMD_WR_OFF));
  a_r7_abort_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && !len_short && !len_long) |=> ($stable(arm_q) && !sr_accept_o));
endmodule

// File: rtl/spi_wperm_ctrl.sv
module spi_wperm_ctrl
  import spi_wp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              csn_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              pe_req_i,
  input  logic              pe_done_i,
  input  logic              aai_enter_i,
  output logic              pe_grant_o,
  output logic              wel_o,
  output logic              aai_o,
  output logic              sr_write_ok_o,
  output logic              sr_accept_o,
  output logic [BYTE_W-1:0] sr_data_o
);
  localparam int PIN_CS = 2, PIN_SCK = 1, PIN_SDI = 0;

  logic [2:0]         pin_lvl, pin_rise, pin_fall;
  logic               frame_end;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] bits;

  spi_wp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({csn_i, sck_i, sdi_i}),
    .level_o (pin_lvl),
    .rise_o  (pin_rise),
    .fall_o  (pin_fall)
  );

  spi_wp_frame u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_rise_i  (pin_rise[PIN_SCK]),
    .sdi_i       (pin_lvl[PIN_SDI]),
    .csn_i       (pin_lvl[PIN_CS]),
    .cs_fall_i   (pin_fall[PIN_CS]),
    .cs_rise_i   (pin_rise[PIN_CS]),
    .frame_end_o (frame_end),
    .bit_cnt_o   (bit_cnt),
    .bits_o      (bits)
  );

  spi_wp_perm u_perm (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_end_i (frame_end),
    .bit_cnt_i   (bit_cnt),
    .bits_i      (bits),
    .pe_req_i    (pe_req_i),
    .pe_done_i   (pe_done_i),
    .aai_enter_i (aai_enter_i),
    .pe_grant_o  (pe_grant_o),
    .wel_o       (wel_o),
    .aai_o       (aai_o),
    .arm_o       (sr_write_ok_o),
    .sr_accept_o (sr_accept_o),
    .sr_data_o   (sr_data_o)
  );

  assign sdo_o    = 1'b0;
  assign sdo_oe_o = 1'b0;

  a_r2_commit_after_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_accept_o || $changed(wel_o) && !$past(pe_done_i) && !$past(pe_req_i))
      |-> $past(pin_rise[PIN_CS]));
  a_r5_accept_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sr_accept_o |=> !sr_accept_o);
endmodule

// File: tb/tb_spi_wperm_ctrl.sv
module tb_spi_wperm_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, csn = 1'b1;
  logic pe_req = 1'b0, pe_done = 1'b0, aai_enter = 1'b0;
  logic sdo, sdo_oe, pe_grant, wel, aai, sr_ok, sr_acc;
  logic [7:0] sr_data;
  int checks = 0, fails = 0, grants = 0, accepts = 0;
  logic [7:0] acc_data = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_wperm_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .csn_i(csn),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .pe_req_i(pe_req), .pe_done_i(pe_done),
    .aai_enter_i(aai_enter), .pe_grant_o(pe_grant), .wel_o(wel), .aai_o(aai),
    .sr_write_ok_o(sr_ok), .sr_accept_o(sr_acc), .sr_data_o(sr_data)
  );

  always @(negedge clk) begin
    if (pe_grant) grants++;
    if (sr_acc) begin accepts++; acc_data = sr_data; end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // inject: 0 none, 1 pe_done on commit edge, 2 aai_enter on commit edge
  task automatic send(input logic [15:0] v, input int nbits, input bit mode3, input int inject);
    sck = mode3; wait_clk(2);
    csn = 1'b0; wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      sdi = v[nbits-1-i];
      sck = 1'b0; wait_clk(4);
      sck = 1'b1; wait_clk(4);
    end
    if (!mode3) begin sck = 1'b0; wait_clk(4); end
    csn = 1'b1;
    wait_clk(2);
    if (inject == 1) pe_done = 1'b1;
    if (inject == 2) aai_enter = 1'b1;
    wait_clk(1);
    pe_done = 1'b0; aai_enter = 1'b0;
    wait_clk(4);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; wait_clk(1); sig = 1'b0; wait_clk(3);
  endtask

  task automatic t_reset;
    check("R1 wel", wel, 0); check("R1 aai", aai, 0);
    check("R1 arm", sr_ok, 0); check("R1 accept", sr_acc, 0);
    check("R1 grant", pe_grant, 0); check("R11 sdo_oe", sdo_oe, 0);
  endtask

  task automatic t_wren_mode0;
    send(16'h06, 8, 1'b0, 0);
    check("R2 wren mode0", wel, 1);
  endtask

  task automatic t_wren_commit_timing;
    send(16'h04, 8, 1'b0, 0);
    sck = 1'b0; wait_clk(2); csn = 1'b0; wait_clk(4);
    for (int i = 0; i < 8; i++) begin
      sdi = i[0] ^ i[1] ? 1'b0 : 1'b0;
      sdi = (8'h06 >> (7 - i)) & 1;
      sck = 1'b0; wait_clk(4); sck = 1'b1; wait_clk(4);
    end
    sck = 1'b0; wait_clk(6);
    check("R2 no commit before cs high", wel, 0);
    csn = 1'b1; wait_clk(2);
    check("R2 not yet on second edge", wel, 0);
    wait_clk(1);
    check("R2 commit on third edge", wel, 1);
    wait_clk(3);
  endtask

  task automatic t_aai_and_wrdi_mode3;
    pulse(aai_enter);
    check("R9 aai set with wel", aai, 1);
    pulse(pe_done);
    check("R8 pe_done clears wel", wel, 0);
    check("R9 aai kept after pe_done", aai, 1);
    send(16'h04, 8, 1'b1, 0);
    check("R3 wrdi wel", wel, 0); check("R3 wrdi aai", aai, 0);
    pulse(aai_enter);
    check("R9 aai refused without wel", aai, 0);
    send(16'h06, 8, 1'b1, 0);
    check("R4 wren mode3", wel, 1);
    send(16'h04, 8, 1'b1, 0);
  endtask

  task automatic t_msb_first;
    send(16'h60, 8, 1'b0, 0);
    check("R4 0x60 is not wren", wel, 0);
  endtask

  task automatic t_abort;
    send(16'h03, 7, 1'b0, 0);
    check("R7 seven bits", wel, 0);
    send(16'h0D, 9, 1'b0, 0);
    check("R7 nine bits", wel, 0);
    send(16'h50, 8, 1'b0, 0);
    check("R5 arm set", sr_ok, 1);
    send(16'h06, 9, 1'b0, 0);
    check("R7 arm survives abort", sr_ok, 1);
    send(16'h01, 8, 1'b0, 0);
    check("R7 short status write aborted", sr_ok, 1);
    check("R7 no accept on abort", accepts, 0);
  endtask

  task automatic t_status_write;
    send(16'h06, 8, 1'b0, 0);
    send(16'h50, 8, 1'b0, 0);
    check("R5 wel before accept", wel, 1);
    send(16'h01A5, 16, 1'b0, 0);
    check("R5 accept count", accepts, 1); check("R5 data", acc_data, 8'hA5);
    check("R5 wel cleared", wel, 0); check("R5 arm cleared", sr_ok, 0);
  endtask

  task automatic t_arm_lost;
    send(16'h50, 8, 1'b1, 0);
    send(16'h06, 8, 1'b1, 0);
    check("R6 arm lost", sr_ok, 0);
    send(16'h013C, 16, 1'b1, 0);
    check("R6 no accept after lost arm", accepts, 1);
    check("R6 wel unchanged", wel, 1);
  endtask

  task automatic t_grant;
    pulse(pe_req);
    check("R8 grant with wel", grants, 1);
    pulse(pe_done);
    pulse(pe_req);
    check("R8 no grant without wel", grants, 1);
  endtask

  task automatic t_collide;
    send(16'h06, 8, 1'b0, 1);
    check("R10 wren beats pe_done", wel, 1);
    send(16'h04, 8, 1'b0, 2);
    check("R10 wrdi beats aai_enter", aai, 0);
    check("R10 wrdi wel", wel, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(3); rst_n = 1'b1; wait_clk(3);
    t_reset;
    t_wren_mode0;
    t_wren_commit_timing;
    t_aai_and_wrdi_mode3;
    t_msb_first;
    t_abort;
    t_status_write;
    t_arm_lost;
    t_grant;
    t_collide;
    check("R11 sdo_oe end", sdo_oe, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule